// File: doc/BRIEF.md
# Memory Access Signature Generator

This block sits behind the retire stage of a core and condenses the stream of retired memory accesses into two compact summaries: one for loads and one for stores. Each summary is a bit vector split into equal bins. Every access address goes through one H3 hash per bin, and each hash sets exactly one bit in its own bin of the summary that matches the access kind. Two summaries that share a set bit in every bin mark a possible address overlap. Later analysis uses that to flag candidate data races.

Work is grouped into epochs. An epoch ends when a synchronization instruction retires, or by force once a fixed number of instructions has retired in it. The block then offers both signatures and an epoch number on an output valid/ready channel toward a signature table. While that handoff is pending, the input ready is held low so that the retire stage stalls and no access is lost. The synchronizing instruction that closes an epoch counts toward the next epoch, and so does its access. When the handoff completes, the signatures restart from zero, or from that instruction's access alone.

Hash matrices are parameters. Row r of hash k is an 8-bit word at `HASH_MATRIX[(k*64 + r)*8 +: 8]`. The index for bin k is the XOR of the rows whose address bit is 1. The address is folded in three sections whose partial results are XORed together.

Top module: `access_sig_gen`

## Requirements
- R1: After reset both signatures are all zero, the epoch number is 0, `in_ready` is 1 and `out_valid` is 0.
- R2: An accepted beat with `in_is_mem`=1, `in_is_store`=0 and `in_is_sync`=0 sets, for each bin k (signature bits `[k*256 +: 256]`), the bit whose index is the XOR of the `HASH_MATRIX` rows of hash k selected by the 1 bits of the address. The write signature is unchanged.
- R3: An accepted non-sync beat with `in_is_mem`=1 and `in_is_store`=1 sets the same kind of bits in the write signature. The read signature is unchanged.
- R4: An accepted non-sync beat with `in_is_mem`=0 changes neither signature, whatever `in_is_store` holds, but still counts one instruction.
- R5: Accepting a beat with `in_is_sync`=1 closes the epoch. From the next cycle `out_valid` is 1 and `in_ready` is 0, and the signatures do not include that beat's access.
- R6: Once the epoch holds 2000 accepted instructions, `out_valid` is 1 from the next cycle without any sync.
- R7: The sync beat that closes an epoch belongs to the new epoch. After the handoff the signatures hold only its access, and the new epoch is forced closed after 1999 further instructions.
- R8: While `out_valid`=1 and `out_ready`=0, the signatures and the epoch number stay constant, and input beats are not accepted.
- R9: A handoff (`out_valid` and `out_ready` both 1 at a clock edge) increments the epoch number by one and clears both signatures, apart from any R7 access.
- R10: The all-zero address maps to bit 0 of every bin.
- R11: Repeating an address already recorded leaves the signature unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retired instruction is offered |
| in_ready | output | 1 | Generator accepts the offered instruction |
| in_addr | input | 64 | Access address |
| in_is_mem | input | 1 | Instruction is a load or a store |
| in_is_store | input | 1 | Access is a store (with in_is_mem) |
| in_is_sync | input | 1 | Instruction is a synchronization point |
| out_valid | output | 1 | Closed epoch's signatures are offered |
| out_ready | input | 1 | Signature table takes the offer |
| out_rd_sig | output | 2048 | Read (load) signature |
| out_wr_sig | output | 2048 | Write (store) signature |
| out_epoch | output | 16 | Number of the epoch being offered |

## Verification
The bench feeds one stream that mixes loads, stores, non-memory instructions, repeated addresses and the zero address. It compares every closed epoch against signatures it computes from its own hash matrices. A design that put the closing sync access in the old epoch, or dropped it, fails the post-handoff signature check. A design that left the sync beat out of the new epoch's count closes one instruction late in the forced-close test. The limit is exercised both from an empty epoch and from one seeded by a sync. That catches an off-by-one limit, and also a counter that ignores non-memory instructions. During a held handoff the bench keeps offering a load. A design that let ready stay high, or let the signatures move, shows an altered signature or a late ready.

// File: rtl/sig_pkg.sv
package sig_pkg;

  localparam int DEF_ADDR_W = 64;
  localparam int DEF_BINS   = 8;
  localparam int DEF_IDX_W  = 8;
  localparam int DEF_MAT_W  = DEF_BINS * DEF_ADDR_W * DEF_IDX_W;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_HAND = 1'b1
  } ctrl_st_e;

  // Integer scrambler used to fill the default hash matrices.
  function automatic logic [31:0] scramble(input logic [31:0] seed);
    logic [31:0] x;
    x = seed * 32'h9E37_79B9;
    x = x ^ (x >> 16);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  // Default H3 matrices: row r of hash k lives at [(k*ADDR_W + r)*IDX_W +: IDX_W].
  function automatic logic [DEF_MAT_W-1:0] default_matrix();
    logic [DEF_MAT_W-1:0] m;
    logic [31:0]          w;
    m = '0;
    for (int k = 0; k < DEF_BINS; k++) begin
      for (int r = 0; r < DEF_ADDR_W; r++) begin
        w = scramble(32'(k * DEF_ADDR_W + r + 1));
        m[(k*DEF_ADDR_W + r)*DEF_IDX_W +: DEF_IDX_W] = w[DEF_IDX_W-1:0];
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/sig_h3_unit.sv
module sig_h3_unit #(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 8,
  parameter int SECTIONS = 3
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W*IDX_W-1:0] rows,
  output logic [IDX_W-1:0]        idx
);

  // XOR of the rows in [lo, hi) whose address bit is set.
  function automatic logic [IDX_W-1:0] fold(
    input logic [ADDR_W-1:0]       a,
    input logic [ADDR_W*IDX_W-1:0] m,
    input int                      lo,
    input int                      hi
  );
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int r = 0; r < ADDR_W; r++) begin
      if (r >= lo && r < hi && a[r]) acc = acc ^ m[r*IDX_W +: IDX_W];
    end
    return acc;
  endfunction

  logic [IDX_W-1:0] part [SECTIONS];

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    localparam int LO = (s * ADDR_W) / SECTIONS;
    localparam int HI = ((s + 1) * ADDR_W) / SECTIONS;
    assign part[s] = fold(addr, rows, LO, HI);
  end

  always_comb begin
    idx = '0;
    for (int s = 0; s < SECTIONS; s++) idx = idx ^ part[s];
  end

endmodule

// File: rtl/sig_bank.sv
module sig_bank #(
  parameter int N_BINS = 8,
  parameter int BIN_W  = 256,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_en,
  input  logic [N_BINS*IDX_W-1:0] add_idx,
  input  logic                    restart,
  input  logic                    seed_en,
  input  logic [N_BINS*IDX_W-1:0] seed_idx,
  output logic [N_BINS*BIN_W-1:0] sig
);

  function automatic logic [BIN_W-1:0] onehot(input logic [IDX_W-1:0] i);
    logic [BIN_W-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  for (genvar k = 0; k < N_BINS; k++) begin : g_bin
    logic [BIN_W-1:0] bin_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bin_q <= '0;
      end else if (restart) begin
        bin_q <= seed_en ? onehot(seed_idx[k*IDX_W +: IDX_W]) : '0;
      end else if (add_en) begin
        bin_q <= bin_q | onehot(add_idx[k*IDX_W +: IDX_W]);
      end
    end
    assign sig[k*BIN_W +: BIN_W] = bin_q;
  end

endmodule

// File: rtl/sig_epoch_ctrl.sv
module sig_epoch_ctrl #(
  parameter int LIMIT   = 2000,
  parameter int CNT_W   = 11,
  parameter int EPOCH_W = 16,
  parameter int VEC_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_is_mem,
  input  logic               in_is_store,
  input  logic               in_is_sync,
  input  logic [VEC_W-1:0]   idx_vec,
  input  logic               out_ready,
  output logic               in_ready,
  output logic               out_valid,
  output logic               add_rd,
  output logic               add_wr,
  output logic               restart,
  output logic               seed_rd,
  output logic               seed_wr,
  output logic [VEC_W-1:0]   pend_idx,
  output logic [EPOCH_W-1:0] epoch,
  output logic [CNT_W-1:0]   count,
  output logic               ev_fire,
  output logic               ev_close_sync,
  output logic               ev_close_limit,
  output logic               ev_hand_done
);

  sig_pkg::ctrl_st_e st_q;
  logic              plain;
  logic              pend_cnt_q;
  logic              pend_rd_q;
  logic              pend_wr_q;
  logic [VEC_W-1:0]  pend_idx_q;

  assign in_ready       = (st_q == sig_pkg::ST_RUN);
  assign out_valid      = (st_q == sig_pkg::ST_HAND);
  assign ev_fire        = in_valid && in_ready;
  assign ev_close_sync  = ev_fire && in_is_sync;
  assign plain          = ev_fire && !in_is_sync;
  assign ev_close_limit = plain && (count == CNT_W'(LIMIT - 1));
  assign ev_hand_done   = out_valid && out_ready;

  assign add_rd   = plain && in_is_mem && !in_is_store;
  assign add_wr   = plain && in_is_mem && in_is_store;
  assign restart  = ev_hand_done;
  assign seed_rd  = pend_rd_q;
  assign seed_wr  = pend_wr_q;
  assign pend_idx = pend_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= sig_pkg::ST_RUN;
    end else if (ev_close_sync || ev_close_limit) begin
      st_q <= sig_pkg::ST_HAND;
    end else if (ev_hand_done) begin
      st_q <= sig_pkg::ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      epoch <= '0;
    end else if (ev_hand_done) begin
      count <= pend_cnt_q ? CNT_W'(1) : '0;
      epoch <= epoch + EPOCH_W'(1);
    end else if (plain) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt_q <= 1'b0;
      pend_rd_q  <= 1'b0;
      pend_wr_q  <= 1'b0;
      pend_idx_q <= '0;
    end else if (ev_close_sync) begin
      pend_cnt_q <= 1'b1;
      pend_rd_q  <= in_is_mem && !in_is_store;
      pend_wr_q  <= in_is_mem && in_is_store;
      pend_idx_q <= idx_vec;
    end else if (ev_hand_done) begin
      pend_cnt_q <= 1'b0;
      pend_rd_q  <= 1'b0;
      pend_wr_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/access_sig_gen.sv
module access_sig_gen #(
  parameter int ADDR_W      = 64,
  parameter int N_BINS      = 8,
  parameter int SIG_W       = 2048,
  parameter int EPOCH_LIMIT = 2000,
  parameter int EPOCH_W     = 16,
  parameter logic [N_BINS*ADDR_W*$clog2(SIG_W/N_BINS)-1:0] HASH_MATRIX =
    sig_pkg::default_matrix()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic               in_is_mem,
  input  logic               in_is_store,
  input  logic               in_is_sync,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SIG_W-1:0]   out_rd_sig,
  output logic [SIG_W-1:0]   out_wr_sig,
  output logic [EPOCH_W-1:0] out_epoch
);

  localparam int BIN_W   = SIG_W / N_BINS;
  localparam int IDX_W   = $clog2(BIN_W);
  localparam int ROWS_W  = ADDR_W * IDX_W;
  localparam int VEC_W   = N_BINS * IDX_W;
  localparam int CNT_W   = $clog2(EPOCH_LIMIT + 1);

  logic [VEC_W-1:0] idx_vec;
  logic [VEC_W-1:0] pend_idx;
  logic             add_rd, add_wr, restart, seed_rd, seed_wr;
  logic [CNT_W-1:0] ep_count;
  logic             ev_fire, ev_close_sync, ev_close_limit, ev_hand_done;

  for (genvar k = 0; k < N_BINS; k++) begin : g_hash
    sig_h3_unit #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .SECTIONS (3)
    ) u_h3 (
      .addr (in_addr),
      .rows (HASH_MATRIX[k*ROWS_W +: ROWS_W]),
      .idx  (idx_vec[k*IDX_W +: IDX_W])
    );
  end

  sig_epoch_ctrl #(
    .LIMIT   (EPOCH_LIMIT),
    .CNT_W   (CNT_W),
    .EPOCH_W (EPOCH_W),
    .VEC_W   (VEC_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_is_mem      (in_is_mem),
    .in_is_store    (in_is_store),
    .in_is_sync     (in_is_sync),
    .idx_vec        (idx_vec),
    .out_ready      (out_ready),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .add_rd         (add_rd),
    .add_wr         (add_wr),
    .restart        (restart),
    .seed_rd        (seed_rd),
    .seed_wr        (seed_wr),
    .pend_idx       (pend_idx),
    .epoch          (out_epoch),
    .count          (ep_count),
    .ev_fire        (ev_fire),
    .ev_close_sync  (ev_close_sync),
    .ev_close_limit (ev_close_limit),
    .ev_hand_done   (ev_hand_done)
  );

  sig_bank #(
    .N_BINS (N_BINS),
    .BIN_W  (BIN_W),
    .IDX_W  (IDX_W)
  ) u_rd_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (add_rd),
    .add_idx  (idx_vec),
    .restart  (restart),
    .seed_en  (seed_rd),
    .seed_idx (pend_idx),
    .sig      (out_rd_sig)
  );

  sig_bank #(
    .N_BINS (N_BINS),
    .BIN_W  (BIN_W),
    .IDX_W  (IDX_W)
  ) u_wr_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (add_wr),
    .add_idx  (idx_vec),
    .restart  (restart),
    .seed_en  (seed_wr),
    .seed_idx (pend_idx),
    .sig      (out_wr_sig)
  );

endmodule

// File: rtl/sig_checker.sv
module sig_checker #(
  parameter int N_BINS  = 8,
  parameter int SIG_W   = 2048,
  parameter int EPOCH_W = 16,
  parameter int CNT_W   = 11,
  parameter int LIMIT   = 2000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               in_is_sync,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SIG_W-1:0]   out_rd_sig,
  input logic [SIG_W-1:0]   out_wr_sig,
  input logic [EPOCH_W-1:0] out_epoch,
  input logic [CNT_W-1:0]   ep_count,
  input logic               ev_fire,
  input logic               ev_close_sync,
  input logic               ev_close_limit,
  input logic               ev_hand_done
);

  p_ready_off_in_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_sync_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close_sync |=> out_valid);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ep_count <= CNT_W'(LIMIT));

  p_limit_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close_limit |=> (out_valid && ep_count == CNT_W'(LIMIT)));

  p_fresh_epoch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hand_done |=> (($countones(out_rd_sig) + $countones(out_wr_sig)) <= N_BINS
                      && ep_count <= CNT_W'(1)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rd_sig)
                                   && $stable(out_wr_sig) && $stable(out_epoch)));

  p_no_accept_in_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ev_fire);

  p_epoch_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hand_done |=> (out_epoch == $past(out_epoch) + EPOCH_W'(1)));

  p_sig_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !in_is_sync) |=> (((out_rd_sig & $past(out_rd_sig)) == $past(out_rd_sig))
                                  && ((out_wr_sig & $past(out_wr_sig)) == $past(out_wr_sig))));

endmodule

bind access_sig_gen sig_checker #(
  .N_BINS  (N_BINS),
  .SIG_W   (SIG_W),
  .EPOCH_W (EPOCH_W),
  .CNT_W   (CNT_W),
  .LIMIT   (EPOCH_LIMIT)
) u_chk (.*);

// File: tb/sim_access_sig_gen.sv
module sim_access_sig_gen;

  localparam int AW  = 64;
  localparam int NB  = 8;
  localparam int SW  = 2048;
  localparam int BW  = SW / NB;
  localparam int IW  = 8;
  localparam int LIM = 2000;
  localparam int EW  = 16;

  function automatic logic [IW-1:0] tb_row(input int k, input int r);
    return IW'(((r + 1) * (2 * k + 3) * 29) ^ (r * k + 7));
  endfunction

  function automatic logic [NB*AW*IW-1:0] tb_matrix();
    logic [NB*AW*IW-1:0] m;
    m = '0;
    for (int k = 0; k < NB; k++)
      for (int r = 0; r < AW; r++)
        m[(k*AW + r)*IW +: IW] = tb_row(k, r);
    return m;
  endfunction

  localparam logic [NB*AW*IW-1:0] TB_MAT = tb_matrix();

  // Bits an address sets: per bin, XOR of the selected rows.
  function automatic logic [SW-1:0] tb_mark(input logic [AW-1:0] a);
    logic [SW-1:0] s;
    logic [IW-1:0] h;
    s = '0;
    for (int k = 0; k < NB; k++) begin
      h = '0;
      for (int r = 0; r < AW; r++) if (a[r]) h = h ^ tb_row(k, r);
      s[k*BW + int'(h)] = 1'b1;
    end
    return s;
  endfunction

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic          in_is_mem = 1'b0;
  logic          in_is_store = 1'b0;
  logic          in_is_sync = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [SW-1:0] out_rd_sig;
  logic [SW-1:0] out_wr_sig;
  logic [EW-1:0] out_epoch;

  access_sig_gen #(
    .ADDR_W      (AW),
    .N_BINS      (NB),
    .SIG_W       (SW),
    .EPOCH_LIMIT (LIM),
    .EPOCH_W     (EW),
    .HASH_MATRIX (TB_MAT)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_addr     (in_addr),
    .in_is_mem   (in_is_mem),
    .in_is_store (in_is_store),
    .in_is_sync  (in_is_sync),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_rd_sig  (out_rd_sig),
    .out_wr_sig  (out_wr_sig),
    .out_epoch   (out_epoch)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Bench model
  logic [SW-1:0] exp_rd = '0, exp_wr = '0;
  logic [SW-1:0] pend_rd = '0, pend_wr = '0;
  bit            pend_has = 1'b0;
  int            exp_cnt = 0;
  logic [EW-1:0] exp_ep = '0;
  bit            exp_close = 1'b0;

  task automatic chk_val(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_sig(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one instruction; returns at the negedge after acceptance.
  task automatic send(input logic [AW-1:0] a, input bit mem, input bit st, input bit sy);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_is_mem = mem; in_is_store = st; in_is_sync = sy;
    @(negedge clk);
    in_valid = 1'b0; in_is_sync = 1'b0; in_is_mem = 1'b0; in_is_store = 1'b0;
    exp_close = 1'b0;
    if (sy) begin
      pend_has  = 1'b1;
      pend_rd   = (mem && !st) ? tb_mark(a) : '0;
      pend_wr   = (mem && st) ? tb_mark(a) : '0;
      exp_close = 1'b1;
    end else begin
      if (mem && !st) exp_rd = exp_rd | tb_mark(a);
      if (mem && st)  exp_wr = exp_wr | tb_mark(a);
      exp_cnt++;
      if (exp_cnt == LIM) exp_close = 1'b1;
    end
  endtask

  // Take the offered epoch after 'hold' stalled cycles.
  task automatic handoff(input int hold, input string tag);
    chk_val({tag, " out_valid at close"}, longint'(out_valid), 1);
    chk_val({tag, " in_ready low at close"}, longint'(in_ready), 0);
    chk_sig({tag, " read signature"}, out_rd_sig, exp_rd);
    chk_sig({tag, " write signature"}, out_wr_sig, exp_wr);
    chk_val({tag, " epoch"}, longint'(out_epoch), longint'(exp_ep));
    if (hold > 0) begin
      in_valid = 1'b1; in_addr = 64'h5A5A_0000_C3C3_0011; in_is_mem = 1'b1;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk_val("R8 out_valid held", longint'(out_valid), 1);
        chk_val("R8 in_ready held low", longint'(in_ready), 0);
        chk_sig("R8 read signature stable", out_rd_sig, exp_rd);
        chk_sig("R8 write signature stable", out_wr_sig, exp_wr);
      end
      in_valid = 1'b0; in_is_mem = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    exp_ep  = exp_ep + EW'(1);
    exp_rd  = pend_has ? pend_rd : '0;
    exp_wr  = pend_has ? pend_wr : '0;
    exp_cnt = pend_has ? 1 : 0;
    pend_has = 1'b0;
    chk_val("R9 out_valid after handoff", longint'(out_valid), 0);
    chk_val("R9 in_ready after handoff", longint'(in_ready), 1);
    chk_val("R9 epoch incremented", longint'(out_epoch), longint'(exp_ep));
    chk_sig("R9 R7 read signature restart", out_rd_sig, exp_rd);
    chk_sig("R9 R7 write signature restart", out_wr_sig, exp_wr);
  endtask

  // {close, sync, store, mem, addr}
  localparam logic [67:0] TBL [16] = '{
    {4'b0001, 64'h1000_0000_0000_0040},   // R2 load
    {4'b0011, 64'hDEAD_BEEF_0000_1230},   // R3 store
    {4'b0010, 64'hFFFF_0000_FFFF_0000},   // R4 non-memory, store flag set
    {4'b0001, 64'h1000_0000_0000_0040},   // R11 repeat
    {4'b0011, 64'h0123_4567_89AB_CDEF},   // R3 store
    {4'b1100, 64'h0000_0000_0000_0000},   // R5 sync, no access
    {4'b0001, 64'hAAAA_5555_AAAA_5555},   // R2 load
    {4'b1101, 64'h7777_0000_1111_2222},   // R7 sync carrying a load
    {4'b0011, 64'h8000_0000_0000_0001},   // R3 store
    {4'b0001, 64'h0000_0001_0000_0000},   // R2 load
    {4'b0000, 64'h1234_0000_0000_9999},   // R4 non-memory
    {4'b1111, 64'h3333_4444_5555_6666},   // R7 sync carrying a store
    {4'b0001, 64'h0FED_CBA9_8765_4321},   // R2 load
    {4'b0011, 64'h0FED_CBA9_8765_4321},   // R3 same address as store
    {4'b0001, 64'h0000_0000_0000_0001},   // R2 load
    {4'b1100, 64'h0000_0000_0000_0000}    // R5 sync, no access
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_val("R1 in_ready", longint'(in_ready), 1);
    chk_val("R1 out_valid", longint'(out_valid), 0);
    chk_val("R1 epoch", longint'(out_epoch), 0);
    chk_sig("R1 read signature", out_rd_sig, '0);
    chk_sig("R1 write signature", out_wr_sig, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk
    for (int i = 0; i < 16; i++) begin
      send(TBL[i][63:0], TBL[i][64], TBL[i][65], TBL[i][66]);
      chk_val($sformatf("R5 close flag of entry %0d", i), longint'(out_valid), longint'(TBL[i][67]));
      if (TBL[i][67]) handoff(0, "R5 table");
      else begin
        chk_sig("R2 R4 read signature", out_rd_sig, exp_rd);
        chk_sig("R3 R4 write signature", out_wr_sig, exp_wr);
      end
    end

    // R10 zero address
    send(64'h0, 1'b1, 1'b0, 1'b0);
    chk_val("R10 zero address sets one bit per bin", longint'($countones(out_rd_sig)), NB);
    for (int k = 0; k < NB; k++)
      chk_val("R10 bit 0 of bin", longint'(out_rd_sig[k*BW]), 1);
    // R11 repeat changes nothing
    send(64'h0, 1'b1, 1'b0, 1'b0);
    chk_sig("R11 repeat address", out_rd_sig, exp_rd);
    // R8 held handoff with an offered load
    send(64'h0, 1'b0, 1'b0, 1'b1);
    handoff(4, "R8");

    // R7: sync seeds the new epoch; forced close after LIM-1 more
    send(64'h2468_ACE0_1357_9BDF, 1'b1, 1'b0, 1'b1);
    handoff(0, "R7 seed");
    for (int i = 0; i < LIM - 2; i++) send(64'(i), 1'b0, 1'b0, 1'b0);
    chk_val("R7 not closed one short of limit", longint'(out_valid), 0);
    send(64'h9, 1'b0, 1'b0, 1'b0);
    chk_val("R7 forced close counts the sync beat", longint'(out_valid), 1);
    handoff(0, "R7 forced");

    // R6: empty epoch, mixed traffic up to the limit
    for (int i = 0; i < LIM - 1; i++)
      send(64'(i * 4099), (i % 3) != 0, (i % 3) == 2, 1'b0);
    chk_val("R6 not closed before limit", longint'(out_valid), 0);
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    chk_val("R6 forced close at limit", longint'(out_valid), 1);
    chk_val("R6 model agrees", longint'(exp_close), 1);
    handoff(2, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule